// File: doc/BRIEF.md
# OUT/SETUP Receive Buffer Manager

This block sits between a USB full-speed protocol engine and driver software. It handles the host-to-device data stage of OUT and SETUP transactions. Packet storage is a 2 KB byte array split into 32 slots of 64 bytes, and each slot is named by a 5-bit slot number. Software keeps a four-entry queue of free slot numbers topped up. When a packet arrives for an endpoint that may receive, the block takes the slot at the head of that queue and writes the payload into the slot byte by byte. When the packet ends it reports the packet to software through a four-entry completion queue.

The ACK/NAK decision is made when the token arrives. A packet is taken only if all three of these hold: its endpoint is enabled, a free slot is waiting, and the completion queue has room. Otherwise the packet is answered with NAK. A taken packet whose CRC fails gets no handshake, so the host sends it again. The slot it was using stays at the head of the free queue. An interrupt line stays high while completions are waiting. Software reads slot contents through a plain read address port.

Top module: `rx_buf_mgr`

## Requirements
- R1: The free-slot queue holds up to 4 slot numbers. `free_full` is high when it holds 4. A push while it is full is ignored, and the ignored number is never handed out.
- R2: A packet whose endpoint number is 12 or above, or whose bit in `ep_rx_en` (bit n = endpoint n) is 0, is answered with `hs_nak` high for exactly the cycle after `pk_end`. No completion entry is created.
- R3: A packet that arrives while the free-slot queue is empty is answered with NAK.
- R4: A packet that arrives while the completion queue holds 4 entries is answered with NAK. The free-slot queue is left untouched.
- R5: In a taken packet, stream byte i is written to memory address slot*64 + i.
- R6: A taken packet that ends with good CRC gets `hs_ack` high for exactly the cycle after `pk_end`. In that same cycle a completion entry {slot, length, setup flag, endpoint} appears. The slot is removed from the free queue. Completions come out in arrival order.
- R7: A taken packet ending with `pk_crc_ok` low, or with fewer than 2 stream bytes, gets neither ACK nor NAK and no completion entry. Its slot stays at the head of the free queue and is used by the next taken packet.
- R8: `rx_irq` is high exactly while the completion queue is non-empty.
- R9: A packet whose stream holds only the two CRC bytes is reported with length 0.
- R10: The reported length is the stream byte count minus 2 (the CRC). Stream bytes at offsets 64 and above are not written anywhere, so a 64-byte payload reports length 64 and leaves the next slot unchanged.
- R11: `hs_ack` and `hs_nak` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_push | input | 1 | Push a free slot number |
| free_id | input | 5 | Slot number to push |
| free_full | output | 1 | Free-slot queue holds 4 entries |
| ep_rx_en | input | 12 | Per-endpoint receive enable |
| pk_start | input | 1 | Token pulse: a data packet follows |
| pk_ep | input | 4 | Endpoint of the token |
| pk_setup | input | 1 | 1 = SETUP, 0 = OUT |
| pk_valid | input | 1 | Stream byte valid |
| pk_data | input | 8 | Stream byte (payload then 2 CRC bytes) |
| pk_end | input | 1 | End of packet pulse |
| pk_crc_ok | input | 1 | CRC status, sampled with pk_end |
| hs_ack | output | 1 | ACK handshake pulse |
| hs_nak | output | 1 | NAK handshake pulse |
| done_pop | input | 1 | Pop the head completion |
| done_valid | output | 1 | Completion queue not empty |
| done_id | output | 5 | Slot of head completion |
| done_len | output | 7 | Payload length of head completion |
| done_setup | output | 1 | Head completion was SETUP |
| done_ep | output | 4 | Endpoint of head completion |
| rx_irq | output | 1 | Packet-received interrupt |
| mem_raddr | input | 11 | Memory read address |
| mem_rdata | output | 8 | Memory read data (combinational) |

## Verification
The hardest case to reach is a full completion queue while a free slot is still waiting. Only in that case does the NAK come from the completion queue alone. The stimulus first fills both queues with four slots and sends four good packets without popping. It then pushes one extra slot and sends a fifth packet. That fifth packet must be refused, and the extra slot must survive it. The bench proves this after draining: the next packet lands in that extra slot.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   localparam int RXB_ID_W  = 5;
   localparam int RXB_LEN_W = 7;
   localparam int RXB_EP_W  = 4;

   typedef struct packed {
      logic [RXB_ID_W-1:0]  id;
      logic [RXB_LEN_W-1:0] len;
      logic                 setup;
      logic [RXB_EP_W-1:0]  ep;
   } rxb_done_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RECV = 2'd1,
      ST_DROP = 2'd2
   } rxb_state_t;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         valid,
   output logic         full
);
   localparam int PW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW      = $clog2(DEPTH + 1);
   localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxb_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign valid   = cnt != '0;
   assign full    = cnt == CW'(DEPTH);
   assign do_push = push && !full;
   assign do_pop  = pop && valid;
   assign dout    = mem[rp];

   if (IS_POW2) begin : g_wrap_pow2
      assign wp_nxt = wp + 1'b1;
      assign rp_nxt = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_nxt = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nxt = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) begin
            mem[wp] <= din;
            wp      <= wp_nxt;
         end
         if (do_pop) rp <= rp_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == CW'(DEPTH)));
   assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !valid && !push) |=> (cnt == '0));
endmodule

// File: rtl/rxb_mem.sv
module rxb_mem #(
   parameter int NUM_BUF   = 32,
   parameter int BUF_BYTES = 64
) (
   input  logic                                  clk,
   input  logic                                  we,
   input  logic [$clog2(NUM_BUF*BUF_BYTES)-1:0]  waddr,
   input  logic [7:0]                            wdata,
   input  logic [$clog2(NUM_BUF*BUF_BYTES)-1:0]  raddr,
   output logic [7:0]                            rdata
);
   localparam int BYTES = NUM_BUF * BUF_BYTES;

   logic [7:0] arr [BYTES];

   always_ff @(posedge clk) begin
      if (we) arr[waddr] <= wdata;
   end

   assign rdata = arr[raddr];
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
   import rxb_pkg::*;
#(
   parameter int NUM_EP    = 12,
   parameter int BUF_BYTES = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pk_start,
   input  logic [RXB_EP_W-1:0]   pk_ep,
   input  logic                  pk_setup,
   input  logic                  pk_valid,
   input  logic [7:0]            pk_data,
   input  logic                  pk_end,
   input  logic                  pk_crc_ok,
   input  logic [NUM_EP-1:0]     ep_rx_en,
   input  logic                  av_valid,
   input  logic [RXB_ID_W-1:0]   av_head,
   input  logic                  q_full,
   output logic                  av_pop,
   output logic                  q_push,
   output rxb_done_t             q_entry,
   output logic                  mem_we,
   output logic [RXB_ID_W+$clog2(BUF_BYTES)-1:0] mem_waddr,
   output logic [7:0]            mem_wdata,
   output logic                  hs_ack,
   output logic                  hs_nak
);
   localparam int OFF_W   = $clog2(BUF_BYTES);
   localparam int EP_SPAN = 1 << RXB_EP_W;
   localparam logic [RXB_LEN_W-1:0] CNT_MAX = '1;

   rxb_state_t            st;
   logic [RXB_ID_W-1:0]   cur_id;
   logic [RXB_EP_W-1:0]   cur_ep;
   logic                  cur_setup;
   logic [RXB_LEN_W-1:0]  cnt;
   logic [EP_SPAN-1:0]    en_ext;
   logic                  take, end_recv, good_end;

   assign en_ext   = EP_SPAN'(ep_rx_en);
   assign take     = en_ext[pk_ep] && av_valid && !q_full;
   assign end_recv = (st == ST_RECV) && pk_end && !pk_start;
   assign good_end = end_recv && pk_crc_ok && (cnt >= RXB_LEN_W'(2));

   assign q_push        = good_end;
   assign av_pop        = good_end;
   assign q_entry.id    = cur_id;
   assign q_entry.len   = cnt - RXB_LEN_W'(2);
   assign q_entry.setup = cur_setup;
   assign q_entry.ep    = cur_ep;

   assign mem_we    = (st == ST_RECV) && pk_valid && !pk_start && !pk_end
                      && (cnt < RXB_LEN_W'(BUF_BYTES));
   assign mem_waddr = {cur_id, cnt[OFF_W-1:0]};
   assign mem_wdata = pk_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_id    <= '0;
         cur_ep    <= '0;
         cur_setup <= 1'b0;
         cnt       <= '0;
         hs_ack    <= 1'b0;
         hs_nak    <= 1'b0;
      end else begin
         hs_ack <= good_end;
         hs_nak <= (st == ST_DROP) && pk_end && !pk_start;
         if (pk_start) begin
            st        <= take ? ST_RECV : ST_DROP;
            cur_id    <= av_head;
            cur_ep    <= pk_ep;
            cur_setup <= pk_setup;
            cnt       <= '0;
         end else if (pk_end) begin
            st <= ST_IDLE;
         end else if (st == ST_RECV && pk_valid && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assert_ack_nak_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_ack && hs_nak));
   assert_push_then_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |=> hs_ack);
   assert_push_has_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> av_valid);
   assert_nak_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hs_nak |-> $past(pk_end));
endmodule

// File: rtl/rx_buf_mgr.sv
module rx_buf_mgr
   import rxb_pkg::*;
#(
   parameter int NUM_BUF   = 32,
   parameter int BUF_BYTES = 64,
   parameter int NUM_EP    = 12,
   parameter int AV_DEPTH  = 4,
   parameter int RXQ_DEPTH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  free_push,
   input  logic [4:0]            free_id,
   output logic                  free_full,
   input  logic [11:0]           ep_rx_en,
   input  logic                  pk_start,
   input  logic [3:0]            pk_ep,
   input  logic                  pk_setup,
   input  logic                  pk_valid,
   input  logic [7:0]            pk_data,
   input  logic                  pk_end,
   input  logic                  pk_crc_ok,
   output logic                  hs_ack,
   output logic                  hs_nak,
   input  logic                  done_pop,
   output logic                  done_valid,
   output logic [4:0]            done_id,
   output logic [6:0]            done_len,
   output logic                  done_setup,
   output logic [3:0]            done_ep,
   output logic                  rx_irq,
   input  logic [10:0]           mem_raddr,
   output logic [7:0]            mem_rdata
);
   localparam int OFF_W  = $clog2(BUF_BYTES);
   localparam int ADDR_W = $clog2(NUM_BUF * BUF_BYTES);
   localparam int ENT_W  = $bits(rxb_done_t);

   if (NUM_BUF != (1 << RXB_ID_W)) begin : g_bad_nbuf
      $error("rx_buf_mgr: NUM_BUF must match the slot number width");
   end
   if ((BUF_BYTES & (BUF_BYTES - 1)) != 0 || BUF_BYTES + 2 >= (1 << RXB_LEN_W)) begin : g_bad_bytes
      $error("rx_buf_mgr: BUF_BYTES must be a power of two that fits the length field");
   end
   if (NUM_EP != 12 || ADDR_W != RXB_ID_W + OFF_W || ADDR_W != 11) begin : g_bad_ports
      $error("rx_buf_mgr: parameters do not match the port widths");
   end

   logic                 av_valid, av_pop, q_full, q_push, mem_we;
   logic [RXB_ID_W-1:0]  av_head;
   rxb_done_t            q_entry, q_head;
   logic [ENT_W-1:0]     q_head_raw;
   logic [ADDR_W-1:0]    mem_waddr;
   logic [7:0]           mem_wdata;

   rxb_fifo #(.W(RXB_ID_W), .DEPTH(AV_DEPTH)) u_free (
      .clk(clk), .rst_n(rst_n), .push(free_push), .din(free_id),
      .pop(av_pop), .dout(av_head), .valid(av_valid), .full(free_full));

   rxb_fifo #(.W(ENT_W), .DEPTH(RXQ_DEPTH)) u_done (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_entry),
      .pop(done_pop), .dout(q_head_raw), .valid(done_valid), .full(q_full));

   rxb_ctrl #(.NUM_EP(NUM_EP), .BUF_BYTES(BUF_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .pk_start(pk_start), .pk_ep(pk_ep),
      .pk_setup(pk_setup), .pk_valid(pk_valid), .pk_data(pk_data),
      .pk_end(pk_end), .pk_crc_ok(pk_crc_ok), .ep_rx_en(ep_rx_en),
      .av_valid(av_valid), .av_head(av_head), .q_full(q_full),
      .av_pop(av_pop), .q_push(q_push), .q_entry(q_entry),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .hs_ack(hs_ack), .hs_nak(hs_nak));

   rxb_mem #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES)) u_mem (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(mem_raddr), .rdata(mem_rdata));

   assign q_head     = q_head_raw;
   assign done_id    = q_head.id;
   assign done_len   = q_head.len;
   assign done_setup = q_head.setup;
   assign done_ep    = q_head.ep;
   assign rx_irq     = done_valid;

   assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> hs_ack);
   assert_write_in_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_waddr[ADDR_W-1:OFF_W] == $past(av_head) || $past(pk_valid)));
endmodule

// File: tb/sim_rx_buf_mgr.sv
module sim_rx_buf_mgr;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic free_push = 1'b0;
   logic [4:0] free_id = '0;
   logic free_full;
   logic [11:0] ep_rx_en = 12'h007;
   logic pk_start = 1'b0, pk_setup = 1'b0, pk_valid = 1'b0, pk_end = 1'b0, pk_crc_ok = 1'b0;
   logic [3:0] pk_ep = '0;
   logic [7:0] pk_data = '0;
   logic hs_ack, hs_nak, done_pop = 1'b0, done_valid, done_setup, rx_irq;
   logic [4:0] done_id;
   logic [6:0] done_len;
   logic [3:0] done_ep;
   logic [10:0] mem_raddr = '0;
   logic [7:0] mem_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [16:0] expq [$];

   always #5 clk = ~clk;

   rx_buf_mgr u0 (.*);

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic free(int id);
      @(negedge clk); free_push = 1'b1; free_id = 5'(id);
      @(negedge clk); free_push = 1'b0;
   endtask

   // hs: 0 none, 1 ack, 2 nak
   task automatic send(int ep, bit setup, int n, bit crc, int base, int hs, int id, string req);
      @(negedge clk); pk_start = 1'b1; pk_ep = 4'(ep); pk_setup = setup;
      @(negedge clk); pk_start = 1'b0;
      for (int i = 0; i < n + 2; i++) begin
         pk_valid = 1'b1;
         pk_data = (i < n) ? 8'(base + i) : 8'(8'hC0 + i);
         @(negedge clk);
      end
      pk_valid = 1'b0; pk_end = 1'b1; pk_crc_ok = crc;
      @(negedge clk); pk_end = 1'b0;
      chk({hs_nak, hs_ack} == 2'(hs), req, int'({hs_nak, hs_ack}), hs);
      if (hs == 1) expq.push_back({5'(id), 7'(n), setup, 4'(ep)});
      @(negedge clk);
      chk(!hs_ack && !hs_nak, "R11 one-cycle handshake", int'({hs_nak, hs_ack}), 0);
   endtask

   task automatic rd(int addr, int exp, string req);
      mem_raddr = 11'(addr); #1;
      chk(mem_rdata === 8'(exp), req, int'(mem_rdata), exp);
   endtask

   // monitor side of the scoreboard: pop and compare in arrival order
   task automatic drain;
      while (expq.size() > 0) begin
         logic [16:0] e;
         e = expq.pop_front();
         chk(done_valid && {done_id, done_len, done_setup, done_ep} == e,
             "R6 completion entry", int'({done_id, done_len, done_setup, done_ep}), int'(e));
         done_pop = 1'b1; @(negedge clk); done_pop = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_valid && !rx_irq && !free_full && !hs_ack && !hs_nak, "R8 reset state",
          int'({done_valid, rx_irq, free_full}), 0);
      free(4); free(7); free(3); free(31);
      chk(free_full, "R1 full after four", free_full, 1);
      free(9);                                      // R1: ignored
      send(0, 1'b1, 8, 1'b1, 8'h10, 1, 4, "R6 SETUP ack");
      chk(rx_irq, "R8 irq with entry", rx_irq, 1);
      for (int i = 0; i < 8; i++) rd(4 * 64 + i, 8'h10 + i, "R5 payload byte");
      rd(4 * 64 + 9, 8'hC9, "R5 CRC byte stored");
      send(5, 1'b0, 3, 1'b1, 8'h20, 2, 0, "R2 disabled endpoint NAK");
      send(13, 1'b0, 3, 1'b1, 8'h20, 2, 0, "R2 out-of-range endpoint NAK");
      send(2, 1'b0, 10, 1'b0, 8'h30, 0, 0, "R7 bad CRC silent");
      send(2, 1'b0, 0, 1'b1, 8'h40, 1, 7, "R9 zero length ack");
      send(1, 1'b0, 64, 1'b1, 8'h50, 1, 3, "R10 full payload ack");
      rd(3 * 64 + 63, 8'h50 + 63, "R10 last payload byte");
      rd(4 * 64, 8'h10, "R10 next slot untouched");
      send(0, 1'b0, 0, 1'b1, 8'h60, 1, 31, "R6 fourth packet");
      free(20);
      send(0, 1'b0, 2, 1'b1, 8'h70, 2, 0, "R4 completion queue full NAK");
      drain();
      chk(!rx_irq, "R8 irq low when empty", rx_irq, 0);
      send(1, 1'b0, 5, 1'b1, 8'h80, 1, 20, "R4 slot kept after NAK");
      rd(20 * 64 + 4, 8'h84, "R5 slot 20 byte");
      drain();
      send(0, 1'b0, 1, 1'b1, 8'h90, 2, 0, "R3 no free slot NAK");
      chk(!done_valid, "R3 no entry", done_valid, 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule